// File: doc/BRIEF.md
# Multi-Mode Programmable Counter Channel

This block is one timer channel. It is built around a 16-bit down counter that can be preset. The counter steps once for each single-cycle count-enable pulse, all in one synchronous clock domain. A control write chooses one of six waveform behaviours for the output pin and chooses binary or BCD decrement. A count write supplies the initial value. A separate "first byte" strobe marks the start of a count rewrite, and a "count complete" strobe carries the full 16-bit value. A GATE input enables counting, triggers it, or resets it, depending on the mode. The live count is always visible on an output bus, so surrounding logic can latch it and read it.

The six behaviours cover a wide range of uses:
- interrupt on terminal count
- retriggerable one-shot
- rate generator with a one-count low pulse
- square wave, with the longer half high when the count is odd
- strobe started by software
- strobe started by a GATE edge

Byte sequencing and the register interface are left to the enclosing logic.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `tmr_out` is 1, `cnt_val` is 0 and the channel is idle. No count changes until a mode and a count have been written.
- R2: Mode code 0. Writing the mode drives `tmr_out` low, and loading a count keeps it low and places the value in the counter. Each enable pulse with synchronized GATE high decrements the counter, while GATE low holds it. When the counter reaches 0, `tmr_out` rises and stays high, and counting stops.
- R3: Mode code 0. A `ld_first` strobe halts a count in progress and forces `tmr_out` low. The following `ld_done` starts counting from the new value.
- R4: Mode code 1. `tmr_out` stays high after the mode and count writes. A GATE rising edge loads the count and drives `tmr_out` low. It rises again on the enable pulse that brings the counter to 0, whatever the GATE level.
- R5: Mode code 1 or 5. A count written while counting leaves the running count unchanged. A later GATE rising edge restarts the count from the most recently written value.
- R6: Mode code 2, with count N of at least 2. After loading, `tmr_out` is low for exactly one enable interval out of every N, and the counter reloads N on that pulse. GATE low forces `tmr_out` high and holds the count. A GATE rising edge reloads N.
- R7: Mode code 3, with count N of at least 2. `tmr_out` is high for (N+1)/2 enable intervals and low for N/2, repeating. After enable pulse k (counting from load), the expected level is 1 exactly when k mod N < (N+1)/2.
- R8: Mode code 4. Writing the mode drives `tmr_out` high, and loading starts the count. The enable pulse that reaches 0 drives `tmr_out` low, and the next enable pulse restores it high. GATE low holds the count.
- R9: Mode code 5. Loading leaves `tmr_out` high and does not start counting. A GATE rising edge loads the count. The terminal enable pulse gives a low strobe one enable interval long.
- R10: With BCD selected (`bcd_sel`=1), each decrement borrows per decimal digit, so 0x0100 becomes 0x0099 and 0x0000 wraps to 0x9999. In binary, 0x0000 wraps to 0xFFFF. In both cases an initial count of 0 gives the longest period.
- R11: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R12: GATE passes through a two-stage synchronizer. A rising edge takes effect on the third clock edge after the change. The count changes only on an enable pulse, a count load or a GATE rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Single-cycle count step pulse |
| gate_in | input | 1 | Asynchronous GATE level |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode code, read on `mode_wr` |
| bcd_sel | input | 1 | 1 = BCD decrement, read on `mode_wr` |
| ld_first | input | 1 | First byte of a count rewrite seen |
| ld_done | input | 1 | Count complete strobe |
| ld_value | input | 16 | Initial count, read on `ld_done` |
| tmr_out | output | 1 | Channel output waveform |
| cnt_val | output | 16 | Live counter value |

## Verification
The bound checker watches several rules on every cycle:
- in the interrupt mode, the output rises only at a zero count;
- the one-shot output falls only after a synchronized GATE edge;
- a strobe low in modes 4 and 5 always sits on a zero count;
- GATE low forces the rate-generator output high;
- BCD steps keep every digit in the range 0 to 9;
- GATE edges last one cycle;
- the count holds when there is no step, load or trigger.

Other properties depend on sequences that only the bench's directed scenarios show:
- exact periods and duty ratios;
- the odd-count square-wave asymmetry;
- deferred loads and retriggering;
- mode aliases;
- the three-edge GATE latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [2:0] {
    MD_TC_INT  = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SW_STB  = 3'd4,
    MD_HW_STB  = 3'd5
  } md_e;

  // codes 6 and 7 fold onto the rate and square behaviours
  function automatic md_e norm_mode(input logic [2:0] code);
    case (code)
      3'd0: return MD_TC_INT;
      3'd1: return MD_ONESHOT;
      3'd2: return MD_RATE;
      3'd3: return MD_SQUARE;
      3'd4: return MD_SW_STB;
      3'd5: return MD_HW_STB;
      3'd6: return MD_RATE;
      default: return MD_SQUARE;
    endcase
  endfunction

  // one step down, binary or digit-wise decimal with borrow
  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic             brw;
    logic [3:0]       nib;
    if (!bcd) return v - 1'b1;
    r   = v;
    brw = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      nib = v[i*4 +: 4];
      if (brw) begin
        if (nib == 4'd0) nib = 4'd9;
        else begin
          nib = nib - 4'd1;
          brw = 1'b0;
        end
      end
      r[i*4 +: 4] = nib;
    end
    return r;
  endfunction

  // drop the unit bit: valid for both binary and decimal coding
  function automatic logic [CNT_W-1:0] even_part(input logic [CNT_W-1:0] v);
    return {v[CNT_W-1:1], 1'b0};
  endfunction

  function automatic logic bcd_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/tmr_gate_sync.sv
module tmr_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic lvl,
  output logic rise
);
  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d_in};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tmr_dec.sv
module tmr_dec
  import tmr_pkg::*;
(
  input  logic [CNT_W-1:0] cur,
  input  logic             bcd,
  output logic [CNT_W-1:0] dec1,
  output logic [CNT_W-1:0] dec2
);
  assign dec1 = cnt_dec(cur, bcd);
  assign dec2 = cnt_dec(dec1, bcd);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate_in,
  input  logic             mode_wr,
  input  logic [2:0]       mode_sel,
  input  logic             bcd_sel,
  input  logic             ld_first,
  input  logic             ld_done,
  input  logic [CNT_W-1:0] ld_value,
  output logic             tmr_out,
  output logic [CNT_W-1:0] cnt_val
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  md_e              mode_q;
  logic             bcd_q;
  logic [CNT_W-1:0] cnt_q, init_q;
  logic             out_r, run_q, armed_q, strobe_q, odd_q;

  logic             gate_s, gate_rise;
  logic [CNT_W-1:0] dec1, dec2;

  tmr_gate_sync #(.STAGES(SYNC_STAGES)) u_gsync (
    .clk(clk), .rst_n(rst_n), .d_in(gate_in), .lvl(gate_s), .rise(gate_rise)
  );

  tmr_dec u_dec (.cur(cnt_q), .bcd(bcd_q), .dec1(dec1), .dec2(dec2));

  // named internal events, in priority order
  logic busy_ev, edge_mode, periodic, trig_ev, inhib_ev, tick_ok, gate_ok, step_ev, restore_ev;
  assign busy_ev    = mode_wr | ld_done | ld_first;
  assign edge_mode  = (mode_q == MD_ONESHOT) || (mode_q == MD_HW_STB);
  assign periodic   = (mode_q == MD_RATE) || (mode_q == MD_SQUARE);
  assign trig_ev    = !busy_ev && gate_rise && ((edge_mode && armed_q) || (periodic && run_q));
  assign inhib_ev   = !busy_ev && !trig_ev && periodic && !gate_s;
  assign tick_ok    = !busy_ev && !trig_ev && !inhib_ev && cnt_en;
  assign gate_ok    = edge_mode ? 1'b1 : gate_s;
  assign step_ev    = tick_ok && run_q && gate_ok;
  assign restore_ev = tick_ok && strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_TC_INT;
      bcd_q    <= 1'b0;
      cnt_q    <= '0;
      init_q   <= '0;
      out_r    <= 1'b1;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      strobe_q <= 1'b0;
      odd_q    <= 1'b0;
    end else if (mode_wr) begin
      mode_q   <= norm_mode(mode_sel);
      bcd_q    <= bcd_sel;
      out_r    <= (norm_mode(mode_sel) != MD_TC_INT);
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else if (ld_done) begin
      init_q  <= ld_value;
      armed_q <= 1'b1;
      case (mode_q)
        MD_TC_INT: begin
          cnt_q <= ld_value;
          out_r <= 1'b0;
          run_q <= 1'b1;
        end
        MD_SW_STB: begin
          cnt_q    <= ld_value;
          out_r    <= 1'b1;
          run_q    <= 1'b1;
          strobe_q <= 1'b0;
        end
        MD_RATE: if (!run_q) begin
          cnt_q <= ld_value;
          out_r <= 1'b1;
          run_q <= 1'b1;
        end
        MD_SQUARE: if (!run_q) begin
          cnt_q <= even_part(ld_value);
          odd_q <= ld_value[0];
          out_r <= 1'b1;
          run_q <= 1'b1;
        end
        default: ; // edge-triggered modes wait for GATE
      endcase
    end else if (ld_first) begin
      if (mode_q == MD_TC_INT) begin
        run_q <= 1'b0;
        out_r <= 1'b0;
      end
    end else if (trig_ev) begin
      case (mode_q)
        MD_ONESHOT: begin
          cnt_q <= init_q;
          out_r <= 1'b0;
          run_q <= 1'b1;
        end
        MD_HW_STB: begin
          cnt_q    <= init_q;
          out_r    <= 1'b1;
          run_q    <= 1'b1;
          strobe_q <= 1'b0;
        end
        MD_RATE: begin
          cnt_q <= init_q;
          out_r <= 1'b1;
        end
        default: begin
          cnt_q <= even_part(init_q);
          odd_q <= init_q[0];
          out_r <= 1'b1;
        end
      endcase
    end else if (inhib_ev) begin
      out_r <= 1'b1;
    end else begin
      if (restore_ev) begin
        out_r    <= 1'b1;
        strobe_q <= 1'b0;
      end
      if (step_ev) begin
        case (mode_q)
          MD_TC_INT, MD_ONESHOT: begin
            cnt_q <= dec1;
            if (dec1 == '0) begin
              out_r <= 1'b1;
              run_q <= 1'b0;
            end
          end
          MD_SW_STB, MD_HW_STB: begin
            cnt_q <= dec1;
            if (dec1 == '0) begin
              out_r    <= 1'b0;
              strobe_q <= 1'b1;
              run_q    <= 1'b0;
            end
          end
          MD_RATE: begin
            if (cnt_q == ONE) begin
              cnt_q <= init_q;
              out_r <= 1'b0;
            end else begin
              cnt_q <= dec1;
              out_r <= 1'b1;
            end
          end
          default: begin
            if (out_r && odd_q && cnt_q == '0) begin
              // extra high interval of an odd count
              out_r <= 1'b0;
              cnt_q <= even_part(init_q);
              odd_q <= init_q[0];
            end else if (cnt_q == TWO && !(out_r && odd_q)) begin
              out_r <= ~out_r;
              cnt_q <= even_part(init_q);
              odd_q <= init_q[0];
            end else begin
              cnt_q <= dec2;
            end
          end
        endcase
      end
    end
  end

  assign tmr_out = out_r;
  assign cnt_val = cnt_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             mode_wr,
  input logic             ld_first,
  input logic             ld_done,
  input logic             tmr_out,
  input logic [CNT_W-1:0] cnt_val,
  input logic [2:0]       mode_q,
  input logic             bcd_q,
  input logic             gate_s,
  input logic             gate_rise,
  input logic             step_ev
);
  // R2
  tc_rise_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TC_INT && $rose(tmr_out)) |-> (cnt_val == '0));

  // R4
  oneshot_fall_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && $fell(tmr_out)) |-> $past(gate_rise));

  // R8
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SW_STB || mode_q == MD_HW_STB) && !tmr_out) |-> (cnt_val == '0));

  // R6
  rate_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && !gate_s && !mode_wr && !ld_done && !ld_first) |=> tmr_out);

  // R10
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && bcd_q && !mode_wr && bcd_ok(cnt_val)) |=> bcd_ok(cnt_val));

  // R12
  gate_edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);

  // R12
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ld_done && !gate_rise) |=> $stable(cnt_val));
endmodule

bind tmr_chan tmr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_wr(mode_wr),
  .ld_first(ld_first), .ld_done(ld_done), .tmr_out(tmr_out), .cnt_val(cnt_val),
  .mode_q(mode_q), .bcd_q(bcd_q), .gate_s(gate_s), .gate_rise(gate_rise),
  .step_ev(step_ev)
);

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, gate_in = 1'b0, mode_wr = 1'b0, bcd_sel = 1'b0;
  logic        ld_first = 1'b0, ld_done = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] ld_value = 16'd0;
  logic        tmr_out;
  logic [15:0] cnt_val;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  tmr_chan dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate_in(gate_in),
    .mode_wr(mode_wr), .mode_sel(mode_sel), .bcd_sel(bcd_sel),
    .ld_first(ld_first), .ld_done(ld_done), .ld_value(ld_value),
    .tmr_out(tmr_out), .cnt_val(cnt_val)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnt_en = 1'b1;
      @(negedge clk) cnt_en = 1'b0;
    end
  endtask

  task automatic wr_mode(input logic [2:0] m, input logic b);
    @(negedge clk) begin mode_sel = m; bcd_sel = b; mode_wr = 1'b1; end
    @(negedge clk) mode_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk) begin ld_value = v; ld_done = 1'b1; end
    @(negedge clk) ld_done = 1'b0;
  endtask

  task automatic first_byte();
    @(negedge clk) ld_first = 1'b1;
    @(negedge clk) ld_first = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk) gate_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 out", {15'd0, tmr_out}, 16'd1);
    check("R1 count", cnt_val, 16'd0);
    tick(1);
    check("R1 idle count", cnt_val, 16'd0);
  endtask

  task automatic t_mode0();
    set_gate(1'b1);
    wr_mode(3'd0, 1'b0);
    check("R2 out after mode", {15'd0, tmr_out}, 16'd0);
    load(16'd5);
    check("R2 count loaded", cnt_val, 16'd5);
    tick(4);
    check("R2 count 1", cnt_val, 16'd1);
    check("R2 out still low", {15'd0, tmr_out}, 16'd0);
    set_gate(1'b0);
    tick(1);
    check("R2 gate hold", cnt_val, 16'd1);
    set_gate(1'b1);
    tick(1);
    check("R2 terminal count", cnt_val, 16'd0);
    check("R2 out high", {15'd0, tmr_out}, 16'd1);
    tick(2);
    check("R2 out stays high", {15'd0, tmr_out}, 16'd1);
    check("R2 count stopped", cnt_val, 16'd0);
  endtask

  task automatic t_rewrite();
    load(16'd10);
    tick(2);
    check("R3 count 8", cnt_val, 16'd8);
    first_byte();
    tick(1);
    check("R3 halted", cnt_val, 16'd8);
    check("R3 out low", {15'd0, tmr_out}, 16'd0);
    load(16'd3);
    check("R3 new count", cnt_val, 16'd3);
    tick(3);
    check("R3 terminal", {15'd0, tmr_out}, 16'd1);
  endtask

  task automatic t_oneshot();
    set_gate(1'b0);
    wr_mode(3'd1, 1'b0);
    load(16'd4);
    tick(1);
    check("R4 idle out", {15'd0, tmr_out}, 16'd1);
    check("R4 idle count", cnt_val, 16'd0);
    // R12: GATE edge acts on the third clock edge
    @(negedge clk) gate_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12 not yet", {15'd0, tmr_out}, 16'd1);
    @(negedge clk);
    check("R12 acted", {15'd0, tmr_out}, 16'd0);
    check("R4 loaded", cnt_val, 16'd4);
    set_gate(1'b0);
    tick(3);
    check("R4 low during", {15'd0, tmr_out}, 16'd0);
    check("R4 count 1", cnt_val, 16'd1);
    tick(1);
    check("R4 high at zero", {15'd0, tmr_out}, 16'd1);
  endtask

  task automatic t_retrig();
    set_gate(1'b1);
    check("R5 started", cnt_val, 16'd4);
    tick(1);
    load(16'd7);
    check("R5 deferred", cnt_val, 16'd3);
    set_gate(1'b0);
    set_gate(1'b1);
    check("R5 retrigger new", cnt_val, 16'd7);
    tick(6);
    check("R5 still low", {15'd0, tmr_out}, 16'd0);
    tick(1);
    check("R5 end", {15'd0, tmr_out}, 16'd1);
  endtask

  task automatic t_rate();
    wr_mode(3'd2, 1'b0);
    load(16'd4);
    check("R6 load out", {15'd0, tmr_out}, 16'd1);
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      check("R6 out", {15'd0, tmr_out}, (k % 4 != 0) ? 16'd1 : 16'd0);
      check("R6 count", cnt_val, (k % 4 == 0) ? 16'd4 : 16'(4 - k % 4));
    end
    set_gate(1'b0);
    check("R6 gate forces high", {15'd0, tmr_out}, 16'd1);
    tick(1);
    check("R6 gate hold", cnt_val, 16'd4);
    set_gate(1'b1);
    tick(3);
    check("R6 resume", cnt_val, 16'd1);
  endtask

  task automatic t_square(input logic [2:0] code, input int n, input string req);
    wr_mode(code, 1'b0);
    load(16'(n));
    for (int k = 1; k <= 2 * n; k++) begin
      tick(1);
      check(req, {15'd0, tmr_out}, ((k % n) < (n + 1) / 2) ? 16'd1 : 16'd0);
    end
  endtask

  task automatic t_alias_rate();
    wr_mode(3'd6, 1'b0);
    load(16'd3);
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      check("R11 code6 out", {15'd0, tmr_out}, (k % 3 != 0) ? 16'd1 : 16'd0);
    end
  endtask

  task automatic t_sw_strobe();
    wr_mode(3'd4, 1'b0);
    check("R8 mode out", {15'd0, tmr_out}, 16'd1);
    load(16'd3);
    tick(2);
    check("R8 before tc", {15'd0, tmr_out}, 16'd1);
    tick(1);
    check("R8 strobe low", {15'd0, tmr_out}, 16'd0);
    check("R8 strobe count", cnt_val, 16'd0);
    tick(1);
    check("R8 restored", {15'd0, tmr_out}, 16'd1);
    tick(1);
    check("R8 single strobe", {15'd0, tmr_out}, 16'd1);
    load(16'd3);
    set_gate(1'b0);
    tick(1);
    check("R8 gate hold", cnt_val, 16'd3);
  endtask

  task automatic t_hw_strobe();
    logic [15:0] c0;
    wr_mode(3'd5, 1'b0);
    load(16'd2);
    check("R9 load out", {15'd0, tmr_out}, 16'd1);
    c0 = cnt_val;
    tick(1);
    check("R9 no start", cnt_val, c0);
    set_gate(1'b1);
    check("R9 trigger", cnt_val, 16'd2);
    tick(1);
    check("R9 counting out", {15'd0, tmr_out}, 16'd1);
    tick(1);
    check("R9 strobe", {15'd0, tmr_out}, 16'd0);
    tick(1);
    check("R9 restore", {15'd0, tmr_out}, 16'd1);
    set_gate(1'b0);
    set_gate(1'b1);
    tick(1);
    check("R9 rerun", cnt_val, 16'd1);
    set_gate(1'b0);
    set_gate(1'b1);
    check("R5 hw retrigger", cnt_val, 16'd2);
    tick(2);
    check("R9 strobe again", {15'd0, tmr_out}, 16'd0);
  endtask

  task automatic t_bcd();
    wr_mode(3'd0, 1'b1);
    load(16'h0100);
    tick(1);
    check("R10 bcd borrow", cnt_val, 16'h0099);
    load(16'h0000);
    tick(1);
    check("R10 bcd wrap", cnt_val, 16'h9999);
    check("R10 bcd no tc", {15'd0, tmr_out}, 16'd0);
    wr_mode(3'd0, 1'b0);
    load(16'h0000);
    tick(1);
    check("R10 bin wrap", cnt_val, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_rewrite();
    t_oneshot();
    t_retrig();
    t_rate();
    t_square(3'd3, 6, "R7 even");
    t_square(3'd3, 5, "R7 odd");
    t_square(3'd7, 5, "R11 code7");
    t_alias_rate();
    t_sw_strobe();
    t_hw_strobe();
    t_bcd();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule